// File: doc/BRIEF.md
# Game Display Message Encoder

This block turns game state into the byte stream that a host-side display program expects, and hands those bytes one at a time to a serial transmitter. Control logic gives a one-cycle start pulse together with a command code. The encoder then produces one of three messages. Each message opens with a sync byte that has its top bit set. Every byte after the sync byte is a data byte with its top bit clear. When the last byte has been taken, the encoder raises a one-cycle done pulse.

A full frame carries the playfield: a grid of 16 rows by 8 columns, held outside the block in a small memory. The encoder reads this memory one row at a time through a combinational read port. Each cell becomes one data byte. The frame then ends with two 14-bit counters, mana and score. Each counter is sent as a high 7-bit half followed by a low 7-bit half.

The output is a valid/ready stream. The encoder holds valid high and keeps the byte steady until the transmitter accepts it with ready. A byte moves on only in a cycle where both are high. Ready may be low for any number of cycles, and while it is low the stream stalls without losing or repeating bytes. Ready may stay high all the time, and then one byte leaves every cycle.

Top module: `disp_msg_enc`

## Requirements
- R1: After reset, `tx_valid_o` and `done_o` are low, and they stay low until a start is accepted.
- R2: A start with command 0 produces exactly one byte, 0x81.
- R3: A start with command 1 produces 0x80, then {0, score[13:7]}, then {0, score[6:0]}.
- R4: A start with command 2 produces 133 bytes in this order:
  - 0x82;
  - 128 cell bytes, covering rows 0 to 15 in order, and within each row bit 0 up to bit 7, each sent as the byte {7'b0, bit};
  - {0, mana[13:7]}, then {0, mana[6:0]}, then {0, score[13:7]}, then {0, score[6:0]}.
- R5: Mana and score are captured in the cycle the start is accepted. Later changes on `mana_i` and `score_i` do not alter the message in progress.
- R6: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` does not change. The message advances by one byte only in a cycle where both are high.
- R7: `done_o` is high for exactly one cycle, the cycle after the final byte is accepted. A start given in that cycle is accepted, so messages can follow each other with no gap.
- R8: A start that arrives while a message is in progress is ignored, and the current message completes unchanged.
- R9: Command 3 is reserved. A start with command 3 produces no bytes and no done pulse.
- R10: No output byte ever matches 1xxx_xx11. Every byte after a sync byte has bit 7 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a message |
| cmd_i | input | 2 | Message selector: 0 start, 1 over, 2 frame, 3 reserved |
| mana_i | input | 14 | Mana value, captured at an accepted start |
| score_i | input | 14 | Score value, captured at an accepted start |
| grid_addr_o | output | 4 | Row address for the grid memory |
| grid_data_i | input | 8 | Row contents, combinational from `grid_addr_o` |
| tx_valid_o | output | 1 | Output byte is valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| tx_data_o | output | 8 | Output byte |
| done_o | output | 1 | One-cycle pulse after the final byte is accepted |

## Verification
The bench drives random ready stalls to check that a byte is never dropped or repeated. A design that moves on while ready is low would shift every later byte by one position. The bench changes mana and score, and gives a second start, in the middle of a frame. A design that reads the live inputs, or restarts on that start, would send mixed halves or cut the frame short. The bench also starts a new message in the same cycle as the done pulse, to catch an encoder that needs an idle cycle between messages. It sends the example values mana 7 and score 128 to check the order of the halves. Finally it gives the reserved command, to catch a design that sends a sync byte for it.

// File: rtl/disp_msg_pkg.sv
package disp_msg_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_OVER  = 2'd1,
    CMD_FRAME = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  localparam logic [7:0] SYNC_START = 8'h81;
  localparam logic [7:0] SYNC_OVER  = 8'h80;
  localparam logic [7:0] SYNC_FRAME = 8'h82;

  // width of each half of a counter carried in one data byte
  localparam int unsigned HALF_W = 7;

endpackage

// File: rtl/disp_seq_ctrl.sv
module disp_seq_ctrl
  import disp_msg_pkg::*;
#(
  parameter int unsigned CELLS = 128,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  cmd_e             cmd_i,
  input  logic             ready_i,
  output logic             active_o,
  output logic             accept_o,
  output cmd_e             cmd_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_START = '0;
  localparam logic [IDX_W-1:0] LAST_OVER  = IDX_W'(2);
  localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(CELLS + 4);

  logic [IDX_W-1:0] last_idx;
  logic             fire;
  logic             at_end;

  always_comb begin
    unique case (cmd_o)
      CMD_START: last_idx = LAST_START;
      CMD_OVER:  last_idx = LAST_OVER;
      default:   last_idx = LAST_FRAME;
    endcase
  end

  assign fire     = active_o && ready_i;
  assign at_end   = idx_o == last_idx;
  assign accept_o = !active_o && start_i && (cmd_i != CMD_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cmd_o    <= CMD_START;
      idx_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) begin
        active_o <= 1'b1;
        cmd_o    <= cmd_i;
        idx_o    <= '0;
      end else if (fire) begin
        if (at_end) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> $stable(cmd_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  idx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !ready_i) |=> (active_o && $stable(idx_o)));

endmodule

// File: rtl/disp_byte_fmt.sv
module disp_byte_fmt
  import disp_msg_pkg::*;
#(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned COLS  = 8,
  parameter int unsigned VAL_W = 14,
  parameter int unsigned IDX_W = 8
) (
  input  cmd_e                    cmd_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [VAL_W-1:0]        mana_i,
  input  logic [VAL_W-1:0]        score_i,
  input  logic [COLS-1:0]         row_data_i,
  output logic [$clog2(ROWS)-1:0] row_addr_o,
  output logic [7:0]              byte_o
);

  localparam int unsigned CELLS = ROWS * COLS;
  localparam int unsigned ROW_W = $clog2(ROWS);
  localparam int unsigned COL_W = $clog2(COLS);

  localparam logic [IDX_W-1:0] I_CELL_END = IDX_W'(CELLS);
  localparam logic [IDX_W-1:0] I_MANA_HI  = IDX_W'(CELLS + 1);
  localparam logic [IDX_W-1:0] I_MANA_LO  = IDX_W'(CELLS + 2);
  localparam logic [IDX_W-1:0] I_SCORE_HI = IDX_W'(CELLS + 3);

  logic [IDX_W-1:0] cell_k;
  logic [COL_W-1:0] col;
  logic [7:0]       mana_hi, mana_lo, score_hi, score_lo;

  assign cell_k     = idx_i - 1'b1;
  assign row_addr_o = ROW_W'(cell_k / COLS);
  assign col        = COL_W'(cell_k % COLS);

  assign mana_hi  = {1'b0, mana_i[VAL_W-1 -: HALF_W]};
  assign mana_lo  = {1'b0, mana_i[HALF_W-1:0]};
  assign score_hi = {1'b0, score_i[VAL_W-1 -: HALF_W]};
  assign score_lo = {1'b0, score_i[HALF_W-1:0]};

  always_comb begin
    byte_o = 8'h00;
    unique case (cmd_i)
      CMD_START: byte_o = SYNC_START;
      CMD_OVER: begin
        if (idx_i == '0)           byte_o = SYNC_OVER;
        else if (idx_i == IDX_W'(1)) byte_o = score_hi;
        else                       byte_o = score_lo;
      end
      default: begin
        if (idx_i == '0)              byte_o = SYNC_FRAME;
        else if (idx_i <= I_CELL_END) byte_o = {7'b0, row_data_i[col]};
        else if (idx_i == I_MANA_HI)  byte_o = mana_hi;
        else if (idx_i == I_MANA_LO)  byte_o = mana_lo;
        else if (idx_i == I_SCORE_HI) byte_o = score_hi;
        else                          byte_o = score_lo;
      end
    endcase
  end

endmodule

// File: rtl/disp_msg_enc.sv
module disp_msg_enc
  import disp_msg_pkg::*;
#(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned COLS  = 8,
  parameter int unsigned VAL_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [1:0]              cmd_i,
  input  logic [VAL_W-1:0]        mana_i,
  input  logic [VAL_W-1:0]        score_i,
  output logic [$clog2(ROWS)-1:0] grid_addr_o,
  input  logic [COLS-1:0]         grid_data_i,
  output logic                    tx_valid_o,
  input  logic                    tx_ready_i,
  output logic [7:0]              tx_data_o,
  output logic                    done_o
);

  localparam int unsigned CELLS  = ROWS * COLS;
  localparam int unsigned MSG_MX = CELLS + 5;
  localparam int unsigned IDX_W  = $clog2(MSG_MX);
  localparam int unsigned NVAL   = 2;

  logic             active, accept;
  cmd_e             cmd_q;
  logic [IDX_W-1:0] idx;

  logic [VAL_W-1:0] val_in [NVAL];
  logic [VAL_W-1:0] val_q  [NVAL];

  assign val_in[0] = mana_i;
  assign val_in[1] = score_i;

  disp_seq_ctrl #(.CELLS(CELLS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cmd_i    (cmd_e'(cmd_i)),
    .ready_i  (tx_ready_i),
    .active_o (active),
    .accept_o (accept),
    .cmd_o    (cmd_q),
    .idx_o    (idx),
    .done_o   (done_o)
  );

  for (genvar v = 0; v < NVAL; v++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q[v] <= '0;
      else if (accept) val_q[v] <= val_in[v];
    end

    // R5
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> $stable(val_q[v]));
  end

  disp_byte_fmt #(.ROWS(ROWS), .COLS(COLS), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_fmt (
    .cmd_i      (cmd_q),
    .idx_i      (idx),
    .mana_i     (val_q[0]),
    .score_i    (val_q[1]),
    .row_data_i (grid_data_i),
    .row_addr_o (grid_addr_o),
    .byte_o     (tx_data_o)
  );

  assign tx_valid_o = active;

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R10
  no_bad_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> !(tx_data_o[7] && (tx_data_o[1:0] == 2'b11)));

  // R9
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid_o && start_i && cmd_i == 2'd3) |=> !tx_valid_o);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(tx_valid_o && tx_ready_i));

endmodule

// File: tb/disp_msg_enc_tb_top.sv
module disp_msg_enc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cmd_i = 2'd0;
  logic [13:0] mana_i = '0;
  logic [13:0] score_i = '0;
  logic [3:0]  grid_addr_o;
  logic [7:0]  grid_data_i;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b1;
  logic [7:0]  tx_data_o;
  logic        done_o;

  logic [7:0] mem [16];
  assign grid_data_i = mem[grid_addr_o];

  always #10 clk = ~clk;

  disp_msg_enc dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .mana_i(mana_i), .score_i(score_i), .grid_addr_o(grid_addr_o),
    .grid_data_i(grid_data_i), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o), .done_o(done_o)
  );

  int    n_run = 0, n_fail = 0, cycles = 0;
  bit    cmp_en = 0, rnd_ready = 0;
  string phase = "R1";
  logic [7:0] lf = 8'hA5;

  // behavioural reference
  logic [7:0] q_byte [$];
  string      q_tag  [$];
  bit         m_active = 0, m_done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) actual=%0h expected=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  function automatic void push(logic [7:0] b, string t);
    q_byte.push_back(b);
    q_tag.push_back(t);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q_byte.delete(); q_tag.delete();
      m_active = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_active) begin
        if (tx_ready_i) begin
          void'(q_byte.pop_front()); void'(q_tag.pop_front());
          if (q_byte.size() == 0) begin m_active = 0; m_done = 1; end
        end
      end else if (start_i && cmd_i != 2'd3) begin
        m_active = 1;
        case (cmd_i)
          2'd0: push(8'h81, "R2");
          2'd1: begin
            push(8'h80, "R3");
            push({1'b0, score_i[13:7]}, "R3");
            push({1'b0, score_i[6:0]}, "R3");
          end
          default: begin
            push(8'h82, "R4");
            for (int r = 0; r < 16; r++)
              for (int c = 0; c < 8; c++) push({7'b0, mem[r][c]}, "R4");
            push({1'b0, mana_i[13:7]}, "R5");
            push({1'b0, mana_i[6:0]}, "R5");
            push({1'b0, score_i[13:7]}, "R5");
            push({1'b0, score_i[6:0]}, "R5");
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check(tx_valid_o === m_active, "R6", int'(tx_valid_o), int'(m_active));
      check(done_o === m_done, "R7", int'(done_o), int'(m_done));
      if (m_active && tx_valid_o === 1'b1) begin
        check(tx_data_o === q_byte[0], q_tag[0], int'(tx_data_o), int'(q_byte[0]));
        check(!(tx_data_o[7] && tx_data_o[1:0] == 2'b11), "R10", int'(tx_data_o), 0);
      end
    end
    if (cycles > 100000) begin
      check(0, "watchdog", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    start_i = 1'b0;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    tx_ready_i = rnd_ready ? (lf[0] | lf[3]) : 1'b1;
  endtask

  task automatic go(logic [1:0] c, logic [13:0] m, logic [13:0] s);
    start_i = 1'b1; cmd_i = c; mana_i = m; score_i = s;
  endtask

  task automatic wait_done();
    do tick(); while (done_o !== 1'b1);
  endtask

  initial begin
    for (int r = 0; r < 16; r++) mem[r] = 8'(r * 37 + 5);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_valid_o === 1'b0, "R1", int'(tx_valid_o), 0);
    check(done_o === 1'b0, "R1", int'(done_o), 0);
    rst_n = 1'b1;
    tick(); cmp_en = 1;
    repeat (3) tick();

    phase = "R2"; tick(); go(2'd0, 14'd0, 14'd0); wait_done();

    phase = "R3"; rnd_ready = 1;
    tick(); go(2'd1, 14'd0, 14'h2ABC); wait_done();

    phase = "R4 example"; rnd_ready = 0;
    tick(); go(2'd2, 14'd7, 14'd128); wait_done();

    phase = "R5 R8"; rnd_ready = 1;
    tick(); go(2'd2, 14'h3FFF, 14'h1234);
    repeat (20) tick();
    go(2'd1, 14'h0155, 14'h0AAA);
    tick(); mana_i = 14'h0001; score_i = 14'h2000;
    wait_done();

    phase = "R7 back-to-back";
    go(2'd0, 14'd0, 14'd0); wait_done();
    go(2'd1, 14'd3, 14'h3F80); wait_done();
    rnd_ready = 0;
    go(2'd2, 14'h2001, 14'h0003); wait_done();

    phase = "R9";
    go(2'd3, 14'd1, 14'd1);
    repeat (6) tick();
    check(tx_valid_o === 1'b0, "R9", int'(tx_valid_o), 0);

    phase = "R4 stalls"; rnd_ready = 1;
    for (int r = 0; r < 16; r++) mem[r] = 8'(~(r * 11));
    tick(); go(2'd2, 14'h1555, 14'h2AAA); wait_done();
    repeat (3) tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule